// File: doc/BRIEF.md
# Tile Per-Pixel Visibility Resolver

This block settles, for one square screen tile, which fragment ends up visible at every pixel before any pixel shading is started. Rasterized fragments arrive one per handshake. Each one carries a pixel coordinate, a depth, a primitive tag and a flag that says whether its depth is already known. The block keeps one record per pixel: an occupied bit, the nearest depth seen so far and the tag that owns that depth. Every fragment is inserted, whatever order it arrives in.

A fragment whose depth can only be found by shading it does not go straight into the store. The block stops taking fragments and raises a shade-for-depth request that carries the fragment's coordinate and tag. It then waits until the depth comes back, with the same tag, on the feedback port. That depth is inserted with the ordinary comparison, and only then does fragment intake resume.

A marker beat on the fragment stream ends the tile. The block then walks the pixels in raster order and issues one shade request for each occupied pixel, naming the winning tag. After the last pixel it clears the store and accepts the next tile. Every port uses valid/ready handshaking.

Top module: `tile_vis_resolver`

## Requirements
- R1: After reset `frag_ready` is 1 and `sh_valid` and `dq_valid` are 0. A tile whose first beat is the end marker (`frag_eot`=1, other fields ignored) produces no shade request, and `frag_ready` returns to 1.
- R2: A known-depth fragment (`frag_known`=1) that lands on an unoccupied pixel takes ownership of it at any depth value, including the far value 16'hFFFF.
- R3: On an occupied pixel, a known-depth fragment replaces the owner only if its unsigned depth is strictly smaller. A larger depth leaves the owner unchanged.
- R4: A depth equal to the stored depth does not replace the owner, so the earlier fragment wins ties. This applies both to direct inserts and to fed-back depths.
- R5: A fragment with `frag_known`=0 raises `dq_valid` with its x, y and tag, and `frag_ready` stays 0 from then on. After the `dq` handshake, `fb_ready` is 1. The returned `fb_depth` is inserted with the rules of R2 to R4, and `frag_ready` is 1 in the cycle after the feedback handshake.
- R6: No shade request is raised before the end marker has been accepted, and `frag_ready` stays 0 while shade requests are being issued.
- R7: Shade requests follow raster order, with pixel index y*TILE_W+x strictly increasing. There is exactly one request per occupied pixel, carrying its x, y and winning tag, and unoccupied pixels are skipped.
- R8: For fragments with distinct depths per pixel, the set of shade requests is the same whatever order the fragments are submitted in.
- R9: While `dq_valid` or `sh_valid` is 1 and its ready is 0, the valid stays 1 and the carried coordinate and tag stay unchanged.
- R10: Once the last pixel of a tile has been walked, every pixel is unoccupied again. A following tile sees none of the earlier tile's owners.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frag_valid | input | 1 | Fragment or end-marker beat offered |
| frag_ready | output | 1 | Block accepts a fragment beat |
| frag_eot | input | 1 | 1: beat is the end-of-tile marker |
| frag_known | input | 1 | 1: depth field is final; 0: depth needs shading |
| frag_x | input | 3 | Pixel column in the tile |
| frag_y | input | 3 | Pixel row in the tile |
| frag_depth | input | 16 | Unsigned depth, smaller is nearer |
| frag_tag | input | 8 | Primitive tag |
| dq_valid | output | 1 | Shade-for-depth request pending |
| dq_ready | input | 1 | Depth request taken |
| dq_x | output | 3 | Column of the held fragment |
| dq_y | output | 3 | Row of the held fragment |
| dq_tag | output | 8 | Tag of the held fragment |
| fb_valid | input | 1 | Shaded depth returned |
| fb_ready | output | 1 | Block waits for the shaded depth |
| fb_depth | input | 16 | Depth produced by shading |
| fb_tag | input | 8 | Tag of the fragment the depth belongs to |
| sh_valid | output | 1 | Shade request for a visible pixel |
| sh_ready | input | 1 | Shade request taken |
| sh_x | output | 3 | Column of the visible pixel |
| sh_y | output | 3 | Row of the visible pixel |
| sh_tag | output | 8 | Winning tag at that pixel |

## Verification
The assertions rely on two things. The feedback port returns a depth only for the fragment that is currently held, under the tag that was handed out with the request. The producer keeps to one tile at a time and marks its end with a single marker beat. The bench meets both conditions by construction. It handles every depth request inside the same task that sent the unknown-depth fragment, and it answers with that fragment's own tag. It finishes each tile with exactly one marker and drains all shade requests before the next tile starts. Ties, far-value depths, fed-back depths that lose or tie, empty tiles, a back-pressured shade output and reversed submission order all fall inside these limits.

// File: rtl/tvr_pkg.sv
package tvr_pkg;

  typedef enum logic [1:0] {
    ST_INSERT = 2'd0,
    ST_QUERY  = 2'd1,
    ST_AWAIT  = 2'd2,
    ST_EMIT   = 2'd3
  } tvr_state_e;

  // raster index of a pixel: row-major, rows of width w
  function automatic int pix_index(int x, int y, int w);
    return y * w + x;
  endfunction

  function automatic int pix_col(int idx, int w);
    return idx % w;
  endfunction

  function automatic int pix_row(int idx, int w);
    return idx / w;
  endfunction

endpackage

// File: rtl/tvr_vis_store.sv
module tvr_vis_store #(
  parameter int NPIX    = 64,
  parameter int IDX_W   = 6,
  parameter int DEPTH_W = 16,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_req,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DEPTH_W-1:0] wr_depth,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [NPIX-1:0]    occ,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               ev_take
);

  localparam logic [DEPTH_W-1:0] FAR = '1;

  // an empty pixel always yields; otherwise only a strictly nearer depth wins
  function automatic logic beats(input logic held,
                                 input logic [DEPTH_W-1:0] nd,
                                 input logic [DEPTH_W-1:0] od);
    return !held || (nd < od);
  endfunction

  logic [NPIX-1:0]  take;
  logic [TAG_W-1:0] tag_arr [NPIX];

  generate
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
      logic [DEPTH_W-1:0] dep_q;
      logic [TAG_W-1:0]   tag_q;
      logic               occ_q;

      assign take[p] = wr_req && (wr_idx == IDX_W'(p)) && beats(occ_q, wr_depth, dep_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dep_q <= FAR;
          tag_q <= '0;
          occ_q <= 1'b0;
        end else if (clr) begin
          dep_q <= FAR;
          tag_q <= '0;
          occ_q <= 1'b0;
        end else if (take[p]) begin
          dep_q <= wr_depth;
          tag_q <= wr_tag;
          occ_q <= 1'b1;
        end
      end

      assign occ[p]     = occ_q;
      assign tag_arr[p] = tag_q;
    end
  endgenerate

  assign rd_tag  = tag_arr[rd_idx];
  assign ev_take = |take;

endmodule

// File: rtl/tvr_seq.sv
module tvr_seq
  import tvr_pkg::*;
#(
  parameter int NPIX  = 64,
  parameter int IDX_W = 6,
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frag_valid,
  input  logic             frag_eot,
  input  logic             frag_known,
  input  logic [X_W-1:0]   frag_x,
  input  logic [Y_W-1:0]   frag_y,
  input  logic [TAG_W-1:0] frag_tag,
  output logic             frag_ready,
  output logic             dq_valid,
  input  logic             dq_ready,
  input  logic             fb_valid,
  output logic             fb_ready,
  input  logic             sh_ready,
  input  logic             occ_scan,
  output logic             sh_valid,
  output logic [IDX_W-1:0] scan_idx,
  output logic [X_W-1:0]   pend_x,
  output logic [Y_W-1:0]   pend_y,
  output logic [TAG_W-1:0] pend_tag,
  output logic             ins_known,
  output logic             fb_fire,
  output logic             emit_done,
  output tvr_state_e       state
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  tvr_state_e       st_q, st_d;
  logic [IDX_W-1:0] scan_q;
  logic             frag_fire, go_query, go_emit, dq_fire, step;

  assign frag_ready = (st_q == ST_INSERT);
  assign dq_valid   = (st_q == ST_QUERY);
  assign fb_ready   = (st_q == ST_AWAIT);
  assign sh_valid   = (st_q == ST_EMIT) && occ_scan;

  assign frag_fire = frag_ready && frag_valid;
  assign ins_known = frag_fire && !frag_eot && frag_known;
  assign go_query  = frag_fire && !frag_eot && !frag_known;
  assign go_emit   = frag_fire && frag_eot;
  assign dq_fire   = dq_valid && dq_ready;
  assign fb_fire   = fb_ready && fb_valid;
  // an empty pixel is passed over in one cycle, an occupied one waits for the taker
  assign step      = (st_q == ST_EMIT) && (!occ_scan || sh_ready);
  assign emit_done = step && (scan_q == LAST_IDX);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_INSERT: if (go_emit) st_d = ST_EMIT;
                 else if (go_query) st_d = ST_QUERY;
      ST_QUERY:  if (dq_fire) st_d = ST_AWAIT;
      ST_AWAIT:  if (fb_fire) st_d = ST_INSERT;
      ST_EMIT:   if (emit_done) st_d = ST_INSERT;
      default:   st_d = ST_INSERT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_INSERT;
      scan_q   <= '0;
      pend_x   <= '0;
      pend_y   <= '0;
      pend_tag <= '0;
    end else begin
      st_q <= st_d;
      if (go_emit) scan_q <= '0;
      else if (step) scan_q <= emit_done ? '0 : scan_q + 1'b1;
      if (go_query) begin
        pend_x   <= frag_x;
        pend_y   <= frag_y;
        pend_tag <= frag_tag;
      end
    end
  end

  assign scan_idx = scan_q;
  assign state    = st_q;

endmodule

// File: rtl/tile_vis_resolver.sv
module tile_vis_resolver
  import tvr_pkg::*;
#(
  parameter int TILE_W  = 8,
  parameter int TILE_H  = 8,
  parameter int DEPTH_W = 16,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frag_valid,
  output logic               frag_ready,
  input  logic               frag_eot,
  input  logic               frag_known,
  input  logic [$clog2(TILE_W)-1:0] frag_x,
  input  logic [$clog2(TILE_H)-1:0] frag_y,
  input  logic [DEPTH_W-1:0] frag_depth,
  input  logic [TAG_W-1:0]   frag_tag,
  output logic               dq_valid,
  input  logic               dq_ready,
  output logic [$clog2(TILE_W)-1:0] dq_x,
  output logic [$clog2(TILE_H)-1:0] dq_y,
  output logic [TAG_W-1:0]   dq_tag,
  input  logic               fb_valid,
  output logic               fb_ready,
  input  logic [DEPTH_W-1:0] fb_depth,
  input  logic [TAG_W-1:0]   fb_tag,
  output logic               sh_valid,
  input  logic               sh_ready,
  output logic [$clog2(TILE_W)-1:0] sh_x,
  output logic [$clog2(TILE_H)-1:0] sh_y,
  output logic [TAG_W-1:0]   sh_tag
);

  localparam int NPIX  = TILE_W * TILE_H;
  localparam int IDX_W = $clog2(NPIX);
  localparam int X_W   = $clog2(TILE_W);
  localparam int Y_W   = $clog2(TILE_H);

  // named internal events, watched by the bound checker
  logic             ev_ins_known;
  logic             ev_fb_fire;
  logic             ev_emit_done;
  logic             ev_take;
  tvr_state_e       st;

  logic [IDX_W-1:0]   scan_idx, frag_idx, pend_idx, wr_idx;
  logic [X_W-1:0]     pend_x;
  logic [Y_W-1:0]     pend_y;
  logic [TAG_W-1:0]   pend_tag, wr_tag, rd_tag;
  logic [DEPTH_W-1:0] wr_depth;
  logic [NPIX-1:0]    occ;
  logic               wr_req, clr;

  assign frag_idx = IDX_W'(pix_index(int'(frag_x), int'(frag_y), TILE_W));
  assign pend_idx = IDX_W'(pix_index(int'(pend_x), int'(pend_y), TILE_W));

  tvr_seq #(
    .NPIX (NPIX),
    .IDX_W(IDX_W),
    .X_W  (X_W),
    .Y_W  (Y_W),
    .TAG_W(TAG_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .frag_valid(frag_valid),
    .frag_eot  (frag_eot),
    .frag_known(frag_known),
    .frag_x    (frag_x),
    .frag_y    (frag_y),
    .frag_tag  (frag_tag),
    .frag_ready(frag_ready),
    .dq_valid  (dq_valid),
    .dq_ready  (dq_ready),
    .fb_valid  (fb_valid),
    .fb_ready  (fb_ready),
    .sh_ready  (sh_ready),
    .occ_scan  (occ[scan_idx]),
    .sh_valid  (sh_valid),
    .scan_idx  (scan_idx),
    .pend_x    (pend_x),
    .pend_y    (pend_y),
    .pend_tag  (pend_tag),
    .ins_known (ev_ins_known),
    .fb_fire   (ev_fb_fire),
    .emit_done (ev_emit_done),
    .state     (st)
  );

  // one write source per cycle: a direct insert or a returned depth
  assign wr_req   = ev_ins_known || ev_fb_fire;
  assign wr_idx   = ev_fb_fire ? pend_idx : frag_idx;
  assign wr_depth = ev_fb_fire ? fb_depth : frag_depth;
  assign wr_tag   = ev_fb_fire ? fb_tag   : frag_tag;
  assign clr      = ev_emit_done;

  tvr_vis_store #(
    .NPIX   (NPIX),
    .IDX_W  (IDX_W),
    .DEPTH_W(DEPTH_W),
    .TAG_W  (TAG_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_req  (wr_req),
    .wr_idx  (wr_idx),
    .wr_depth(wr_depth),
    .wr_tag  (wr_tag),
    .rd_idx  (scan_idx),
    .occ     (occ),
    .rd_tag  (rd_tag),
    .ev_take (ev_take)
  );

  assign dq_x   = pend_x;
  assign dq_y   = pend_y;
  assign dq_tag = pend_tag;
  assign sh_x   = X_W'(pix_col(int'(scan_idx), TILE_W));
  assign sh_y   = Y_W'(pix_row(int'(scan_idx), TILE_W));
  assign sh_tag = rd_tag;

endmodule

// File: rtl/tvr_chk.sv
module tvr_chk
  import tvr_pkg::*;
#(
  parameter int TILE_W = 8,
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int TAG_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frag_valid,
  input logic             frag_ready,
  input logic             frag_eot,
  input logic             dq_valid,
  input logic             dq_ready,
  input logic [X_W-1:0]   dq_x,
  input logic [Y_W-1:0]   dq_y,
  input logic [TAG_W-1:0] dq_tag,
  input logic             fb_valid,
  input logic             fb_ready,
  input logic [TAG_W-1:0] fb_tag,
  input logic             sh_valid,
  input logic             sh_ready,
  input logic [X_W-1:0]   sh_x,
  input logic [Y_W-1:0]   sh_y,
  input logic [TAG_W-1:0] sh_tag,
  input logic             ev_fb_fire,
  input logic             ev_emit_done,
  input logic             ev_take,
  input tvr_state_e       st
);

  logic             saw_eot, have_last;
  int               last_idx;
  logic [TAG_W-1:0] q_tag;
  int               cur_idx;

  assign cur_idx = pix_index(int'(sh_x), int'(sh_y), TILE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saw_eot   <= 1'b0;
      have_last <= 1'b0;
      last_idx  <= 0;
      q_tag     <= '0;
    end else begin
      if (frag_valid && frag_ready && frag_eot) saw_eot <= 1'b1;
      else if (ev_emit_done) saw_eot <= 1'b0;
      if (ev_emit_done) have_last <= 1'b0;
      else if (sh_valid && sh_ready) begin
        have_last <= 1'b1;
        last_idx  <= cur_idx;
      end
      if (dq_valid && dq_ready) q_tag <= dq_tag;
    end
  end

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frag_ready, dq_valid, fb_ready, sh_valid})); // R5

  AST_QUERY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |=> (dq_valid || fb_ready) && !frag_ready); // R5

  AST_RESUME_AFTER_FB: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fb_fire |=> frag_ready); // R5

  AST_FB_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && fb_ready) |-> (fb_tag == q_tag)); // R5

  AST_NO_EARLY_SHADE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_valid |-> saw_eot); // R6

  AST_NO_WRITE_IN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EMIT) |-> !ev_take); // R6

  AST_RASTER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && have_last) |-> (cur_idx > last_idx)); // R7

  AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && !dq_ready) |=> dq_valid && $stable(dq_x) && $stable(dq_y) && $stable(dq_tag)); // R9

  AST_SH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && !sh_ready) |=> sh_valid && $stable(sh_x) && $stable(sh_y) && $stable(sh_tag)); // R9

  AST_TILE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_emit_done |=> frag_ready && !sh_valid); // R10

endmodule

bind tile_vis_resolver tvr_chk #(
  .TILE_W(TILE_W),
  .X_W   ($clog2(TILE_W)),
  .Y_W   ($clog2(TILE_H)),
  .TAG_W (TAG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frag_valid  (frag_valid),
  .frag_ready  (frag_ready),
  .frag_eot    (frag_eot),
  .dq_valid    (dq_valid),
  .dq_ready    (dq_ready),
  .dq_x        (dq_x),
  .dq_y        (dq_y),
  .dq_tag      (dq_tag),
  .fb_valid    (fb_valid),
  .fb_ready    (fb_ready),
  .fb_tag      (fb_tag),
  .sh_valid    (sh_valid),
  .sh_ready    (sh_ready),
  .sh_x        (sh_x),
  .sh_y        (sh_y),
  .sh_tag      (sh_tag),
  .ev_fb_fire  (ev_fb_fire),
  .ev_emit_done(ev_emit_done),
  .ev_take     (ev_take),
  .st          (st)
);

// File: tb/tile_vis_resolver_tb.sv
module tile_vis_resolver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frag_valid = 1'b0, frag_eot = 1'b0, frag_known = 1'b0;
  logic [2:0]  frag_x = '0, frag_y = '0;
  logic [15:0] frag_depth = '0;
  logic [7:0]  frag_tag = '0;
  logic        frag_ready;
  logic        dq_valid, dq_ready = 1'b0;
  logic [2:0]  dq_x, dq_y;
  logic [7:0]  dq_tag;
  logic        fb_valid = 1'b0, fb_ready;
  logic [15:0] fb_depth = '0;
  logic [7:0]  fb_tag = '0;
  logic        sh_valid, sh_ready = 1'b0;
  logic [2:0]  sh_x, sh_y;
  logic [7:0]  sh_tag;

  always #10 clk = ~clk;

  tile_vis_resolver u_dut (
    .clk(clk), .rst_n(rst_n),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_eot(frag_eot),
    .frag_known(frag_known), .frag_x(frag_x), .frag_y(frag_y),
    .frag_depth(frag_depth), .frag_tag(frag_tag),
    .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_x(dq_x), .dq_y(dq_y), .dq_tag(dq_tag),
    .fb_valid(fb_valid), .fb_ready(fb_ready), .fb_depth(fb_depth), .fb_tag(fb_tag),
    .sh_valid(sh_valid), .sh_ready(sh_ready), .sh_x(sh_x), .sh_y(sh_y), .sh_tag(sh_tag)
  );

  // entry: [31] known, [30:28] x, [27:25] y, [24] 0, [23:8] depth (fed back if unknown), [7:0] tag
  localparam int NA = 12;
  localparam logic [31:0] VEC_A [NA] = '{
    {1'b1, 3'd1, 3'd0, 1'b0, 16'd100,   8'd1},
    {1'b1, 3'd1, 3'd0, 1'b0, 16'd200,   8'd2},
    {1'b1, 3'd1, 3'd0, 1'b0, 16'd50,    8'd3},
    {1'b1, 3'd1, 3'd0, 1'b0, 16'd50,    8'd4},
    {1'b1, 3'd7, 3'd7, 1'b0, 16'hFFFF,  8'd5},
    {1'b0, 3'd0, 3'd0, 1'b0, 16'd300,   8'd6},
    {1'b1, 3'd0, 3'd0, 1'b0, 16'd400,   8'd7},
    {1'b1, 3'd3, 3'd2, 1'b0, 16'd10,    8'd8},
    {1'b0, 3'd3, 3'd2, 1'b0, 16'd5,     8'd9},
    {1'b1, 3'd2, 3'd2, 1'b0, 16'd7,     8'd10},
    {1'b1, 3'd0, 3'd7, 1'b0, 16'd1000,  8'd11},
    {1'b0, 3'd0, 3'd7, 1'b0, 16'd1000,  8'd12}
  };
  localparam int NB = 8;
  localparam logic [31:0] VEC_B [NB] = '{
    {1'b1, 3'd4, 3'd4, 1'b0, 16'd90,  8'd21},
    {1'b1, 3'd4, 3'd4, 1'b0, 16'd30,  8'd22},
    {1'b0, 3'd4, 3'd4, 1'b0, 16'd60,  8'd23},
    {1'b1, 3'd5, 3'd1, 1'b0, 16'd8,   8'd24},
    {1'b1, 3'd5, 3'd1, 1'b0, 16'd9,   8'd25},
    {1'b1, 3'd6, 3'd6, 1'b0, 16'd500, 8'd26},
    {1'b0, 3'd6, 3'd6, 1'b0, 16'd400, 8'd27},
    {1'b1, 3'd0, 3'd3, 1'b0, 16'd1,   8'd28}
  };

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bench reference: per-pixel occupancy, nearest depth, owner
  bit          m_occ [64];
  logic [15:0] m_dep [64];
  logic [7:0]  m_tag [64];
  int          cap_n;
  logic [7:0]  cap_tag [64];
  logic [5:0]  cap_idx [64];
  logic [7:0]  fwd_tag [64];
  logic [5:0]  fwd_idx [64];
  int          fwd_n;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin
      m_occ[i] = 1'b0; m_dep[i] = 16'hFFFF; m_tag[i] = 8'd0;
    end
  endtask

  task automatic model_put(input int idx, input logic [15:0] d, input logic [7:0] t);
    if (!m_occ[idx] || d < m_dep[idx]) begin
      m_occ[idx] = 1'b1; m_dep[idx] = d; m_tag[idx] = t;
    end
  endtask

  task automatic beat(input bit eot, input bit known, input logic [2:0] x, input logic [2:0] y,
                      input logic [15:0] d, input logic [7:0] t);
    @(negedge clk);
    frag_valid = 1'b1; frag_eot = eot; frag_known = known;
    frag_x = x; frag_y = y; frag_depth = d; frag_tag = t;
    while (!frag_ready) @(negedge clk);
    @(posedge clk);
    #1 frag_valid = 1'b0; frag_eot = 1'b0;
  endtask

  task automatic send_entry(input logic [31:0] e);
    logic [2:0] x = e[30:28];
    logic [2:0] y = e[27:25];
    beat(1'b0, e[31], x, y, e[23:8], e[7:0]);
    if (e[31]) begin
      model_put(int'(y) * 8 + int'(x), e[23:8], e[7:0]);
    end else begin
      int w = 0;
      @(negedge clk);
      while (!dq_valid && w < 50) begin @(negedge clk); w++; end
      chk(dq_valid && dq_x == x && dq_y == y && dq_tag == e[7:0], "R5", "depth request coord/tag",
          int'({dq_valid, dq_y, dq_x, dq_tag}), int'({1'b1, y, x, e[7:0]}));
      chk(!frag_ready, "R5", "intake stalled during request", int'(frag_ready), 0);
      dq_ready = 1'b1;
      @(posedge clk);
      #1 dq_ready = 1'b0;
      @(negedge clk);
      chk(fb_ready && !frag_ready, "R5", "waiting on feedback", int'({fb_ready, frag_ready}), 2);
      fb_valid = 1'b1; fb_depth = e[23:8]; fb_tag = e[7:0];
      while (!fb_ready) @(negedge clk);
      @(posedge clk);
      #1 fb_valid = 1'b0;
      @(negedge clk);
      chk(frag_ready, "R5", "intake resumes after feedback", int'(frag_ready), 1);
      model_put(int'(y) * 8 + int'(x), e[23:8], e[7:0]);
    end
  endtask

  // end the tile, then take every shade request and compare with the reference
  task automatic finish_tile(input bit stall_first, input string req);
    int  p = 0, exp_n = 0, guard = 0;
    bit  first = 1'b1;
    chk(!sh_valid, "R6", "no shade before end marker", int'(sh_valid), 0);
    beat(1'b1, 1'b0, 3'd0, 3'd0, 16'd0, 8'd0);
    for (int i = 0; i < 64; i++) if (m_occ[i]) exp_n++;
    cap_n = 0;
    while (guard < 400) begin
      @(negedge clk);
      guard++;
      if (frag_ready) break;
      if (sh_valid) begin
        while (p < 64 && !m_occ[p]) p++;
        chk(p < 64 && int'(sh_y) * 8 + int'(sh_x) == p, "R7", "raster position",
            int'(sh_y) * 8 + int'(sh_x), p);
        if (p < 64)
          chk(sh_tag == m_tag[p], req, "winning tag", int'(sh_tag), int'(m_tag[p]));
        if (stall_first && first) begin
          logic [13:0] snap = {sh_x, sh_y, sh_tag};
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(sh_valid && {sh_x, sh_y, sh_tag} == snap, "R9", "shade request held under backpressure",
                int'({sh_valid, sh_x, sh_y, sh_tag}), int'({1'b1, snap}));
          end
        end
        first = 1'b0;
        if (cap_n < 64) begin
          cap_tag[cap_n] = sh_tag; cap_idx[cap_n] = {sh_y, sh_x};
        end
        cap_n++;
        sh_ready = 1'b1;
        @(posedge clk);
        #1 sh_ready = 1'b0;
        p++;
      end else begin
        chk(!frag_ready, "R6", "intake closed while emitting", int'(frag_ready), 0);
      end
    end
    chk(cap_n == exp_n, "R7", "one request per occupied pixel", cap_n, exp_n);
    chk(frag_ready && !sh_valid, "R10", "tile closed", int'({frag_ready, sh_valid}), 2);
    model_clear();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(frag_ready == 1'b1, "R1", "frag_ready after reset", int'(frag_ready), 1);
    chk(!sh_valid && !dq_valid, "R1", "no requests after reset", int'({sh_valid, dq_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty tile
    finish_tile(1'b0, "R1");

    // R2 R3 R4 R5: table walk, first response back-pressured (R9)
    for (int i = 0; i < NA; i++) send_entry(VEC_A[i]);
    finish_tile(1'b1, "R3");

    // R10: following tile sees nothing of the previous one
    finish_tile(1'b0, "R10");
    beat(1'b0, 1'b1, 3'd1, 3'd0, 16'd60, 8'd40);
    model_put(1, 16'd60, 8'd40);
    finish_tile(1'b0, "R10");
    chk(cap_n == 1 && cap_tag[0] == 8'd40, "R10", "fresh owner despite earlier nearer depth",
        int'(cap_tag[0]), 40);

    // R2: far depth on empty pixel, R4: equal-depth second fragment loses
    beat(1'b0, 1'b1, 3'd2, 3'd5, 16'hFFFF, 8'd50);
    model_put(42, 16'hFFFF, 8'd50);
    beat(1'b0, 1'b1, 3'd2, 3'd5, 16'hFFFF, 8'd51);
    model_put(42, 16'hFFFF, 8'd51);
    finish_tile(1'b0, "R4");
    chk(cap_n == 1 && cap_tag[0] == 8'd50, "R2", "far depth owns empty pixel, tie keeps first",
        int'(cap_tag[0]), 50);

    // R8: forward then reversed submission give the same visible set
    for (int i = 0; i < NB; i++) send_entry(VEC_B[i]);
    finish_tile(1'b0, "R8");
    fwd_n = cap_n;
    for (int i = 0; i < 64; i++) begin fwd_tag[i] = cap_tag[i]; fwd_idx[i] = cap_idx[i]; end
    for (int i = NB - 1; i >= 0; i--) send_entry(VEC_B[i]);
    finish_tile(1'b0, "R8");
    chk(cap_n == fwd_n, "R8", "count equal across orders", cap_n, fwd_n);
    for (int i = 0; i < fwd_n && i < 64; i++)
      chk(cap_tag[i] == fwd_tag[i] && cap_idx[i] == fwd_idx[i], "R8", "request equal across orders",
          int'({cap_idx[i], cap_tag[i]}), int'({fwd_idx[i], fwd_tag[i]}));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule